// File: doc/BRIEF.md
# SPI EEPROM Boot Copier

This block brings a system up from a serial EEPROM. Straight after reset it selects the EEPROM and clocks out the read instruction followed by a zero start address. It then reads a fixed image of whole pages and writes it, byte by byte, into a destination memory through a plain write port (address, data, write strobe). The processor is held off while this runs.

A LED output shows how many pages are still to come, and updates at the end of every page. Once the last byte has arrived, the block deselects the EEPROM. It then stores the program start address, high byte first, at a fixed vector location. Finally it raises a done flag that releases the processor.

The serial clock is the system clock divided by an even parameter. The number of address bytes sent after the instruction is selected at a pin, so the same block serves EEPROMs with 8-, 16- and 24-bit addressing.

Top module: `spi_boot_copier`

## Requirements
- R1: In the first cycle after reset release, spi_cs_n goes low. The first byte shifted on spi_mosi is the read instruction 0x03, most significant bit first.
- R2: addr_len is sampled in the first cycle after reset release. It selects how many all-zero address bytes follow the instruction: code 1 gives one byte, 2 gives two, 3 gives three, and code 0 also gives three. No other clock pulses come before the data phase.
- R3: spi_sclk is low whenever it is idle, and pulses only while spi_cs_n is low. Each high phase lasts CLK_DIV/2 system cycles. spi_mosi changes only while spi_sclk is low, and spi_miso is sampled at the rising edge of spi_sclk.
- R4: Each received data byte produces exactly one single-cycle mem_we pulse. The address of byte n is LOAD_ADDR + n.
- R5: Exactly PAGES*PAGE_BYTES data bytes are copied, in EEPROM order. Each byte is assembled from its eight spi_miso bits, MSB first.
- R6: led shows PAGES out of reset. When the last byte of a page is written, led changes, in the same cycle, to the number of pages still remaining. It only ever steps down by one.
- R7: spi_cs_n goes high after the last data write and before any vector write. Then two consecutive writes follow: START_ADDR[15:8] to VEC_ADDR, then START_ADDR[7:0] to VEC_ADDR+1.
- R8: done rises after the second vector write and stays high until reset. While done is high there are no serial clock pulses, no memory writes, and spi_cs_n stays high.
- R9: While reset is asserted, spi_cs_n is high, spi_sclk, spi_mosi, mem_we and done are low, and led equals PAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_len | input | 2 | Address byte count code (1, 2, 3; 0 means 3) |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| mem_addr | output | MEM_AW | Destination memory address |
| mem_wdata | output | 8 | Destination memory write data |
| mem_we | output | 1 | Destination memory write strobe, one cycle per byte |
| led | output | LED_W | Pages still remaining |
| done | output | 1 | Copy finished, processor may start |

## Verification
Some properties are checked by assertions on every cycle:
- the serial clock pulses only while the EEPROM is selected, and only while a byte is shifting;
- the data line holds steady across each high clock phase;
- the LED count falls by exactly one at a time;
- back-to-back writes land on consecutive addresses;
- done is sticky and quiet.

Other behaviours need the bench's scenarios: the instruction and address bytes seen by a modelled EEPROM under each address-length code, the exact byte order and addresses of a random image, the LED value at each page boundary, and when the deselect happens relative to the vector writes.

// File: rtl/bootcp_pkg.sv
package bootcp_pkg;

   typedef enum logic [2:0] {
      ST_SEL,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_REL,
      ST_VHI,
      ST_VLO,
      ST_DONE
   } boot_state_e;

   // Address-length code to byte count; code 0 falls back to the widest form.
   function automatic logic [1:0] addr_byte_count(input logic [1:0] code);
      return (code == 2'd0) ? 2'd3 : code;
   endfunction

endpackage

// File: rtl/bootcp_shifter.sv
module bootcp_shifter #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte
);

   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic       half_end;
   logic [7:0] tx_sr;
   logic [7:0] rx_sr;
   logic [2:0] bitn;

   // Phase timer: a plain strobe at the minimum divide, a counter otherwise.
   generate
      if (HALF == 1) begin : g_div_min
         assign half_end = busy;
      end else begin : g_div_cnt
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!busy || half_end)
               cnt <= '0;
            else
               cnt <= cnt + CW'(1);
         end
         assign half_end = busy && (cnt == CW'(HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         sclk  <= 1'b0;
         tx_sr <= '0;
         rx_sr <= '0;
         bitn  <= '0;
      end else begin
         done <= 1'b0;
         if (load && !busy) begin
            busy  <= 1'b1;
            tx_sr <= tx_byte;
            bitn  <= '0;
            sclk  <= 1'b0;
         end else if (half_end) begin
            if (!sclk) begin
               sclk  <= 1'b1;
               rx_sr <= {rx_sr[6:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bitn == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitn  <= bitn + 3'd1;
                  tx_sr <= {tx_sr[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi    = busy & tx_sr[7];
   assign rx_byte = rx_sr;

   AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> busy); // R3

   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi)); // R3

endmodule

// File: rtl/bootcp_progress.sv
module bootcp_progress #(
   parameter int PAGES      = 128,
   parameter int PAGE_BYTES = 256,
   parameter int LED_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   output logic             last,
   output logic [LED_W-1:0] led
);

   localparam int BW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
   localparam int PW = $clog2(PAGES + 1);
   localparam logic [BW-1:0] BYTE_LAST = BW'(PAGE_BYTES - 1);

   logic [BW-1:0] byte_cnt;
   logic [PW-1:0] pages_left;
   logic          page_end;

   assign page_end = (byte_cnt == BYTE_LAST);
   assign last     = page_end && (pages_left == PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt   <= '0;
         pages_left <= PW'(PAGES);
         led        <= LED_W'(PAGES);
      end else if (stb) begin
         if (page_end) begin
            byte_cnt   <= '0;
            pages_left <= pages_left - PW'(1);
            led        <= LED_W'(pages_left - PW'(1));
         end else begin
            byte_cnt <= byte_cnt + BW'(1);
         end
      end
   end

   AST_LED_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(led) |-> (led == $past(led) - LED_W'(1))); // R6

   AST_PAGES_NOT_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> (pages_left != '0)); // R5

endmodule

// File: rtl/spi_boot_copier.sv
module spi_boot_copier #(
   parameter int                CLK_DIV    = 2,
   parameter int                PAGES      = 128,
   parameter int                PAGE_BYTES = 256,
   parameter int                MEM_AW     = 16,
   parameter int                LED_W      = 8,
   parameter logic [7:0]        RD_OPCODE  = 8'h03,
   parameter logic [MEM_AW-1:0] LOAD_ADDR  = MEM_AW'(16'h8000),
   parameter logic [15:0]       START_ADDR = 16'h8000,
   parameter logic [MEM_AW-1:0] VEC_ADDR   = MEM_AW'(16'h0001)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_len,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   output logic [LED_W-1:0]  led,
   output logic              done
);

   import bootcp_pkg::*;

   localparam logic [MEM_AW-1:0] VEC_LO = VEC_ADDR + MEM_AW'(1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (PAGES < 1 || PAGE_BYTES < 1) begin : g_bad_size
         $error("PAGES and PAGE_BYTES must be at least 1");
      end
      if (MEM_AW < 2) begin : g_bad_aw
         $error("MEM_AW too small for the vector pair");
      end
      if (LED_W < 1) begin : g_bad_led
         $error("LED_W must be at least 1");
      end
   endgenerate

   boot_state_e       state;
   logic              load;
   logic [7:0]        tx;
   logic [1:0]        addr_left;
   logic [MEM_AW-1:0] dst;
   logic              sh_busy;
   logic              sh_done;
   logic [7:0]        rx_byte;
   logic              byte_stb;
   logic              last_byte;

   bootcp_shifter #(
      .CLK_DIV (CLK_DIV)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .tx_byte (tx),
      .miso    (spi_miso),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .busy    (sh_busy),
      .done    (sh_done),
      .rx_byte (rx_byte)
   );

   assign byte_stb = (state == ST_DATA) && sh_done;

   bootcp_progress #(
      .PAGES      (PAGES),
      .PAGE_BYTES (PAGE_BYTES),
      .LED_W      (LED_W)
   ) u_prog (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (byte_stb),
      .last  (last_byte),
      .led   (led)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_SEL;
         spi_cs_n  <= 1'b1;
         load      <= 1'b0;
         tx        <= '0;
         addr_left <= '0;
         dst       <= LOAD_ADDR;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         done      <= 1'b0;
      end else begin
         load   <= 1'b0;
         mem_we <= 1'b0;
         unique case (state)
            ST_SEL: begin
               spi_cs_n  <= 1'b0;
               load      <= 1'b1;
               tx        <= RD_OPCODE;
               addr_left <= addr_byte_count(addr_len);
               state     <= ST_OPC;
            end
            ST_OPC: begin
               if (sh_done) begin
                  load  <= 1'b1;
                  tx    <= 8'h00;
                  state <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (sh_done) begin
                  load      <= 1'b1;
                  addr_left <= addr_left - 2'd1;
                  if (addr_left == 2'd1)
                     state <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (sh_done) begin
                  mem_we    <= 1'b1;
                  mem_addr  <= dst;
                  mem_wdata <= rx_byte;
                  dst       <= dst + MEM_AW'(1);
                  if (last_byte)
                     state <= ST_REL;
                  else
                     load <= 1'b1;
               end
            end
            ST_REL: begin
               spi_cs_n <= 1'b1;
               state    <= ST_VHI;
            end
            ST_VHI: begin
               mem_we    <= 1'b1;
               mem_addr  <= VEC_ADDR;
               mem_wdata <= START_ADDR[15:8];
               state     <= ST_VLO;
            end
            ST_VLO: begin
               mem_we    <= 1'b1;
               mem_addr  <= VEC_LO;
               mem_wdata <= START_ADDR[7:0];
               state     <= ST_DONE;
            end
            ST_DONE: begin
               done <= 1'b1;
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !spi_cs_n); // R3

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R8

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && !spi_sclk && !mem_we && !sh_busy)); // R8

   AST_PAIR_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + MEM_AW'(1))); // R7

   AST_NO_WRITE_WHILE_SHIFT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && spi_cs_n) |-> !spi_sclk); // R7

endmodule

// File: tb/test_spi_boot_copier.sv
module test_spi_boot_copier;

   localparam int DIV   = 4;
   localparam int NP    = 3;
   localparam int PB    = 8;
   localparam int NB    = NP * PB;
   localparam int AW    = 16;
   localparam int LW    = 8;
   localparam int LOGN  = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    addr_len = 2'd3;
   logic          cs_n, sclk, mosi;
   logic          miso = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          mem_we;
   logic [LW-1:0] led;
   logic          done;

   always #2.5 clk = ~clk;

   spi_boot_copier #(
      .CLK_DIV    (DIV),
      .PAGES      (NP),
      .PAGE_BYTES (PB),
      .MEM_AW     (AW),
      .LED_W      (LW)
   ) i_spi_boot_copier (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_len  (addr_len),
      .spi_cs_n  (cs_n),
      .spi_sclk  (sclk),
      .spi_mosi  (mosi),
      .spi_miso  (miso),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .led       (led),
      .done      (done)
   );

   int ncheck = 0;
   int nfail  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      ncheck++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- EEPROM model (mode 0) ----------------
   logic [7:0]  img [NB];
   int          rcnt = 0;
   int          hdr_bits = 32;
   logic [31:0] hdr = '0;

   always @(negedge cs_n) begin
      rcnt = 0;
      hdr  = '0;
      miso = 1'b0;
   end

   always @(posedge sclk) begin
      if (!cs_n) begin
         if (rcnt < hdr_bits) hdr = {hdr[30:0], mosi};
         rcnt++;
      end
   end

   always @(negedge sclk) begin
      if (!cs_n && rcnt >= hdr_bits) begin
         int idx;
         idx = rcnt - hdr_bits;
         if (idx < NB * 8) miso = img[idx / 8][7 - (idx % 8)];
         else              miso = 1'b0;
      end
   end

   // ---------------- port monitor ----------------
   logic [AW-1:0] wa [LOGN];
   logic [7:0]    wd [LOGN];
   logic [LW-1:0] wl [LOGN];
   int   wcnt = 0;
   int   cs_rise_w = -1;
   int   viol = 0;
   int   hicnt = 0;
   logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (wcnt < LOGN) begin
               wa[wcnt] = mem_addr;
               wd[wcnt] = mem_wdata;
               wl[wcnt] = led;
            end
            wcnt++;
         end
         if (!prev_cs && cs_n && cs_rise_w < 0) cs_rise_w = wcnt;
         if (sclk && cs_n) viol++;
         if (sclk && prev_sclk && mosi != prev_mosi) viol++;
         if (sclk) hicnt++;
         else if (prev_sclk) begin
            if (hicnt != DIV / 2) viol++;
            hicnt = 0;
         end
      end
      prev_sclk = sclk;
      prev_mosi = mosi;
      prev_cs   = cs_n;
   end

   // ---------------- expected-value helpers ----------------
   function automatic int exp_nbytes(input logic [1:0] code);
      return (code == 2'd0) ? 3 : int'(code);
   endfunction

   function automatic logic [31:0] exp_hdr(input int n);
      return 32'h03 << (8 * n);
   endfunction

   function automatic int exp_led(input int i);
      return NP - (i + 1) / PB;
   endfunction

   // ---------------- one boot run ----------------
   task automatic run_boot(input logic [1:0] code, input bit check_reset);
      int n;
      int cyc;
      n = exp_nbytes(code);
      foreach (img[k]) img[k] = 8'($urandom);
      img[0]      = 8'h80;   // corner: MSB only
      img[NB - 1] = 8'h01;   // corner: LSB only
      @(negedge clk);
      rst_n     = 1'b0;
      addr_len  = code;
      hdr_bits  = 8 * (1 + n);
      wcnt      = 0;
      cs_rise_w = -1;
      viol      = 0;
      hicnt     = 0;
      repeat (4) @(negedge clk);
      if (check_reset) begin
         chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R9", "serial pins in reset",
             {cs_n, sclk, mosi}, 3'b100);
         chk(mem_we == 1'b0 && done == 1'b0, "R9", "we/done in reset", {mem_we, done}, 0);
         chk(led == LW'(NP), "R9", "led in reset", led, NP);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 1'b0, "R1", "cs low one cycle after reset", cs_n, 0);
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done == 1'b1, "R8", "done reached before watchdog", done, 1);
      if (!done) return;

      chk(hdr[7 + 8 * n -: 8] == 8'h03, "R1", "instruction byte", hdr[7 + 8 * n -: 8], 8'h03);
      chk(hdr == exp_hdr(n), "R2", "instruction+zero address", hdr, exp_hdr(n));
      chk(rcnt == hdr_bits + 8 * NB, "R2", "total clock pulses", rcnt, hdr_bits + 8 * NB);
      chk(viol == 0, "R3", "clock/data timing violations", viol, 0);
      chk(wcnt == NB + 2, "R4", "total write strobes", wcnt, NB + 2);
      for (int i = 0; i < NB && i < LOGN; i++) begin
         chk(wa[i] == AW'(16'h8000 + i), "R4", $sformatf("addr of byte %0d", i), wa[i], 16'h8000 + i);
         chk(wd[i] == img[i], "R5", $sformatf("data of byte %0d", i), wd[i], img[i]);
         chk(wl[i] == LW'(exp_led(i)), "R6", $sformatf("led at byte %0d", i), wl[i], exp_led(i));
      end
      chk(cs_rise_w == NB, "R7", "deselect after data, before vectors", cs_rise_w, NB);
      chk(wa[NB] == 16'h0001 && wd[NB] == 8'h80, "R7", "vector high byte",
          {wa[NB], wd[NB]}, {16'h0001, 8'h80});
      chk(wa[NB + 1] == 16'h0002 && wd[NB + 1] == 8'h00, "R7", "vector low byte",
          {wa[NB + 1], wd[NB + 1]}, {16'h0002, 8'h00});
      chk(led == '0, "R6", "led after last page", led, 0);

      begin
         int w0, r0;
         bit quiet;
         w0 = wcnt;
         r0 = rcnt;
         quiet = 1'b1;
         repeat (40) begin
            @(negedge clk);
            if (!done || !cs_n || sclk) quiet = 1'b0;
         end
         chk(quiet && wcnt == w0 && rcnt == r0, "R8", "idle after done",
             {quiet, 32'(wcnt - w0)}, {1'b1, 32'd0});
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_B007));
      run_boot(2'd3, 1'b1);
      run_boot(2'd2, 1'b0);
      run_boot(2'd1, 1'b0);
      run_boot(2'd0, 1'b1);
      for (int r = 0; r < 2; r++) run_boot(2'($urandom_range(0, 3)), 1'b0);
      $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
      $finish;
   end

endmodule